// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM command bus and brings the memory from power-on to a usable state. After an active-low asynchronous reset it holds clock-enable low and drives a no-operation command. It waits for a power-good indication and then counts out the mandatory stable-clock interval. After that it raises clock-enable and issues the fixed initialization chain. The chain has two precharge-all commands, an extended mode-register load that enables the DLL, a mode-register load that resets the DLL, a set of auto-refresh commands, and a final mode-register load that programs the operating mode without resetting the DLL again.

Every timing limit is a parameter. Limits given in nanoseconds are turned into clock cycles from the clock period by rounding up. A single down-counter, reloaded each time a step begins, enforces every wait. The DLL lock interval is enforced as the gap that follows the DLL-reset load. When the wait after the last mode-register load has run out, a done flag rises. The flag stays high until the next reset, and from then on the bus carries only no-operation commands.

Top module: `ddr_init_seq`

## Requirements
- R1: From reset, `cke_o` stays low and the bus carries NOP while `pwr_ok_i` is low. Once `pwr_ok_i` is sampled high, `cke_o` stays low for exactly STABLE_CYC further cycles, where STABLE_CYC = ceil(T_STABLE_NS*1000/CLK_PERIOD_PS) (10000 at the defaults).
- R2: `cke_o` rises in a cycle that carries NOP and then stays high until reset. The first precharge-all follows the rise by CKE_NOP_CYC cycles.
- R3: A precharge-all is encoded CS#/RAS#/CAS#/WE# = 0,0,1,0 with address bit 10 high, all other address bits low and bank 0. The next command comes G_RP cycles later.
- R4: The extended mode-register load is the command after the first precharge. It is encoded 0,0,0,0 with bank address 01 and address EMRS_VAL (DLL enabled), and is followed by a G_MRD cycle gap.
- R5: The DLL-reset load comes next, with bank 00 and address MODE_VAL with bit 8 forced high. No further command is issued for G_LOCK = max(2, DLL_LOCK_CYC) cycles.
- R6: A second precharge-all (same encoding as R3) follows the DLL-reset load.
- R7: N_REF auto-refresh commands follow, each encoded 0,0,0,1 with bank 0 and address 0, and each followed by a G_RFC cycle gap.
- R8: The final mode-register load uses bank 00 and address MODE_VAL with bit 8 forced low.
- R9: `init_done_o` rises exactly G_MRD cycles after the final load. It then stays high, with `cke_o` high and NOP on the bus, until reset.
- R10: Every cycle that does not issue a sequenced command drives NOP, encoded 0,1,1,1, with bank and address at zero.
- R11: Asserting `rst_ni` at any point in the chain immediately returns the outputs to `cke_o` low, `init_done_o` low and NOP.
- R12: Nanosecond limits are rounded up to whole cycles, and each gap is at least 2 cycles. At the defaults (20 ns clock) G_RP = 2 (30 ns), G_RFC = 4 (70 ns), G_MRD = 2, CKE_NOP_CYC = 2, G_LOCK = 200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_ok_i | input | 1 | Supplies and clock are stable |
| cke_o | output | 1 | Clock enable to the memory |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address / mode-register value |
| init_done_o | output | 1 | Initialization complete, sticky until reset |

## Verification
The assertions assume that `pwr_ok_i`, once it is high, stays high until the next reset. They also assume that the mode-register parameters leave address bit 10 free of meaning for precharge. The stimulus holds power-good low for a random number of idle cycles and raises it only once per run. It changes the input only on falling clock edges. It breaks the chain only through reset, at random offsets including the cycle right after clock-enable rises. Runs that complete compare every command cycle, encoding, bank and address against a schedule the bench computes from the cycle rules.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_STABLE,
    ST_CKE,
    ST_PRE1,
    ST_EMRS,
    ST_MRS_DLL,
    ST_PRE2,
    ST_REF,
    ST_MRS_OP,
    ST_DONE
  } step_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  localparam cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam cmd_t CMD_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ps);
    longint unsigned num;
    num = longint'(ns) * 1000 + longint'(period_ps) - 1;
    return int'(num / longint'(period_ps));
  endfunction

  function automatic int unsigned at_least2(input int unsigned v);
    return (v < 2) ? 2 : v;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
  import ddr_init_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned STABLE_CYC = 10000,
  parameter int unsigned G_CKE      = 2,
  parameter int unsigned G_RP       = 2,
  parameter int unsigned G_MRD      = 2,
  parameter int unsigned G_LOCK     = 200,
  parameter int unsigned G_RFC      = 4,
  parameter int unsigned N_REF      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_ok_i,
  input  logic             zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] val_o,
  output step_e            step_o,
  output logic             issue_o,
  output logic             cke_o,
  output logic             done_o
);

  localparam int unsigned REF_W = $clog2(N_REF) + 1;

  step_e            step_q, step_d;
  logic             issue_q, issue_d;
  logic [REF_W-1:0] ref_q, ref_d;
  logic [CNT_W-1:0] gap_m2;

  // wait loaded in the issue cycle; the next issue lands gap cycles later
  always_comb begin
    case (step_q)
      ST_CKE:            gap_m2 = CNT_W'(G_CKE - 2);
      ST_PRE1, ST_PRE2:  gap_m2 = CNT_W'(G_RP - 2);
      ST_EMRS, ST_MRS_OP: gap_m2 = CNT_W'(G_MRD - 2);
      ST_MRS_DLL:        gap_m2 = CNT_W'(G_LOCK - 2);
      ST_REF:            gap_m2 = CNT_W'(G_RFC - 2);
      default:           gap_m2 = '0;
    endcase
  end

  always_comb begin
    step_d  = step_q;
    issue_d = issue_q;
    ref_d   = ref_q;
    load_o  = 1'b0;
    val_o   = '0;
    case (step_q)
      ST_IDLE: begin
        if (pwr_ok_i) begin
          step_d = ST_STABLE;
          load_o = 1'b1;
          val_o  = CNT_W'(STABLE_CYC - 1);
        end
      end
      ST_STABLE: begin
        if (zero_i) begin
          step_d  = ST_CKE;
          issue_d = 1'b1;
        end
      end
      ST_DONE: ;
      default: begin
        if (issue_q) begin
          load_o  = 1'b1;
          val_o   = gap_m2;
          issue_d = 1'b0;
        end else if (zero_i) begin
          issue_d = 1'b1;
          case (step_q)
            ST_CKE:     step_d = ST_PRE1;
            ST_PRE1:    step_d = ST_EMRS;
            ST_EMRS:    step_d = ST_MRS_DLL;
            ST_MRS_DLL: step_d = ST_PRE2;
            ST_PRE2:    step_d = ST_REF;
            ST_REF: begin
              if (ref_q == REF_W'(N_REF - 1)) begin
                step_d = ST_MRS_OP;
                ref_d  = '0;
              end else begin
                ref_d  = ref_q + 1'b1;
              end
            end
            ST_MRS_OP: begin
              step_d  = ST_DONE;
              issue_d = 1'b0;
            end
            default: step_d = ST_IDLE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= ST_IDLE;
      issue_q <= 1'b0;
      ref_q   <= '0;
    end else begin
      step_q  <= step_d;
      issue_q <= issue_d;
      ref_q   <= ref_d;
    end
  end

  assign step_o  = step_q;
  assign issue_o = issue_q;
  assign cke_o   = (step_q != ST_IDLE) && (step_q != ST_STABLE);
  assign done_o  = (step_q == ST_DONE);

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned BA_W     = 2,
  parameter int unsigned MODE_VAL = 32'h032,
  parameter int unsigned EMRS_VAL = 32'h000
) (
  input  step_e             step_i,
  input  logic              issue_i,
  output cmd_t              cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [ADDR_W-1:0] A10_MASK = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] A8_MASK  = ADDR_W'(1) << 8;
  localparam logic [ADDR_W-1:0] MODE_W   = ADDR_W'(MODE_VAL);

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    if (issue_i) begin
      case (step_i)
        ST_PRE1, ST_PRE2: begin
          cmd_o  = CMD_PRE;
          addr_o = A10_MASK;
        end
        ST_EMRS: begin
          cmd_o  = CMD_MRS;
          ba_o   = BA_W'(1);
          addr_o = ADDR_W'(EMRS_VAL);
        end
        ST_MRS_DLL: begin
          cmd_o  = CMD_MRS;
          addr_o = MODE_W | A8_MASK;
        end
        ST_REF: cmd_o = CMD_REF;
        ST_MRS_OP: begin
          cmd_o  = CMD_MRS;
          addr_o = MODE_W & ~A8_MASK;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 20000,
  parameter int unsigned T_STABLE_NS   = 200000,
  parameter int unsigned T_RP_NS       = 30,
  parameter int unsigned T_RFC_NS      = 70,
  parameter int unsigned T_MRD_CYC     = 2,
  parameter int unsigned DLL_LOCK_CYC  = 200,
  parameter int unsigned CKE_NOP_CYC   = 2,
  parameter int unsigned N_REF         = 2,
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned BA_W          = 2,
  parameter int unsigned MODE_VAL      = 32'h032,
  parameter int unsigned EMRS_VAL      = 32'h000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ok_i,
  output logic              cke_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o
);

  localparam int unsigned STABLE_CYC = max_u(1, ns_to_cyc(T_STABLE_NS, CLK_PERIOD_PS));
  localparam int unsigned G_CKE      = at_least2(CKE_NOP_CYC);
  localparam int unsigned G_RP       = at_least2(ns_to_cyc(T_RP_NS, CLK_PERIOD_PS));
  localparam int unsigned G_RFC      = at_least2(ns_to_cyc(T_RFC_NS, CLK_PERIOD_PS));
  localparam int unsigned G_MRD      = at_least2(T_MRD_CYC);
  localparam int unsigned G_LOCK     = at_least2(DLL_LOCK_CYC);
  localparam int unsigned MAX_LOAD   = max_u(max_u(STABLE_CYC, G_LOCK),
                                             max_u(max_u(G_RP, G_RFC), max_u(G_MRD, G_CKE)));
  localparam int unsigned CNT_W      = $clog2(MAX_LOAD + 1);

  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             zero;
  step_e            step;
  logic             issue;
  cmd_t             cmd;

  ddr_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (load_val),
    .zero_o (zero)
  );

  ddr_init_fsm #(
    .CNT_W      (CNT_W),
    .STABLE_CYC (STABLE_CYC),
    .G_CKE      (G_CKE),
    .G_RP       (G_RP),
    .G_MRD      (G_MRD),
    .G_LOCK     (G_LOCK),
    .G_RFC      (G_RFC),
    .N_REF      (N_REF)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwr_ok_i (pwr_ok_i),
    .zero_i   (zero),
    .load_o   (load),
    .val_o    (load_val),
    .step_o   (step),
    .issue_o  (issue),
    .cke_o    (cke_o),
    .done_o   (init_done_o)
  );

  ddr_init_cmd_enc #(
    .ADDR_W   (ADDR_W),
    .BA_W     (BA_W),
    .MODE_VAL (MODE_VAL),
    .EMRS_VAL (EMRS_VAL)
  ) u_enc (
    .step_i  (step),
    .issue_i (issue),
    .cmd_o   (cmd),
    .ba_o    (ba_o),
    .addr_o  (addr_o)
  );

  assign cs_no  = cmd.cs_n;
  assign ras_no = cmd.ras_n;
  assign cas_no = cmd.cas_n;
  assign we_no  = cmd.we_n;

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned BA_W         = 2,
  parameter int unsigned DLL_LOCK_CYC = 200
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwr_ok_i,
  input logic              cke_o,
  input logic              cs_no,
  input logic              ras_no,
  input logic              cas_no,
  input logic              we_no,
  input logic [BA_W-1:0]   ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              init_done_o
);

  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] PRE = 4'b0010;
  localparam logic [3:0] REF = 4'b0001;
  localparam logic [3:0] MRS = 4'b0000;

  logic [3:0] cmd;
  assign cmd = {cs_no, ras_no, cas_no, we_no};

  logic dll_mrs;
  assign dll_mrs = (cmd == MRS) && (ba_o == '0) && addr_o[8];

  // cycles since the DLL-reset load, saturating at the lock window
  logic [$clog2(DLL_LOCK_CYC + 2)-1:0] lock_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_cnt <= '0;
    end else if (dll_mrs) begin
      lock_cnt <= 1;
    end else if (lock_cnt != '0 && lock_cnt < DLL_LOCK_CYC) begin
      lock_cnt <= lock_cnt + 1'b1;
    end
  end

  p_cke_low_nop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> cmd == NOP);

  p_cke_rise_nop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> cmd == NOP);

  p_cke_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);

  p_pre_a10_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == PRE |-> addr_o[10] && ba_o == '0);

  p_pre_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == PRE |=> cmd == NOP);

  p_mrs_bank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == MRS |-> ba_o <= BA_W'(1));

  p_mrs_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == MRS |=> cmd == NOP);

  p_dll_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_cnt != '0 && lock_cnt < DLL_LOCK_CYC) |-> cmd == NOP);

  p_ref_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == REF |=> cmd == NOP);

  p_done_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  p_done_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> cke_o && cmd == NOP);

  p_nop_clean_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == NOP |-> ba_o == '0 && addr_o == '0);

endmodule

bind ddr_init_seq ddr_init_seq_chk #(
  .ADDR_W       (ADDR_W),
  .BA_W         (BA_W),
  .DLL_LOCK_CYC (DLL_LOCK_CYC)
) u_chk (.*);

// File: tb/ddr_init_seq_test.sv
`timescale 1ns/1ps
module ddr_init_seq_test;

  localparam int PERIOD_PS = 20000;
  localparam int STAB_NS   = 200000;
  localparam int RP_NS     = 30;
  localparam int RFC_NS    = 70;
  localparam int MRD       = 2;
  localparam int LOCK      = 200;
  localparam int CKE_NOP   = 2;
  localparam int NREF      = 2;
  localparam int AW        = 12;
  localparam int BW        = 2;
  localparam int MODE      = 'h032;
  localparam int EMRS      = 'h000;
  localparam int N_EXP     = 5 + NREF;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  function automatic int ceil_cyc(input int ns);
    return (ns * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  endfunction
  function automatic int min2(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  localparam int STABLE_CYC = (STAB_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [BW-1:0] ba;
  logic [AW-1:0] addr;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  int    exp_cyc  [N_EXP];
  int    exp_cmd  [N_EXP];
  int    exp_ba   [N_EXP];
  int    exp_addr [N_EXP];
  string exp_req  [N_EXP];
  int    exp_done;

  always #10 clk = ~clk;

  ddr_init_seq #(
    .CLK_PERIOD_PS (PERIOD_PS),
    .T_STABLE_NS   (STAB_NS),
    .T_RP_NS       (RP_NS),
    .T_RFC_NS      (RFC_NS),
    .T_MRD_CYC     (MRD),
    .DLL_LOCK_CYC  (LOCK),
    .CKE_NOP_CYC   (CKE_NOP),
    .N_REF         (NREF),
    .ADDR_W        (AW),
    .BA_W          (BW),
    .MODE_VAL      (MODE),
    .EMRS_VAL      (EMRS)
  ) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pwr_ok_i    (pwr),
    .cke_o       (cke),
    .cs_no       (cs_n),
    .ras_no      (ras_n),
    .cas_no      (cas_n),
    .we_no       (we_n),
    .ba_o        (ba),
    .addr_o      (addr),
    .init_done_o (done)
  );

  function automatic logic [3:0] cur_cmd();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic add_exp(input int idx, input int cyc, input logic [3:0] c,
                         input int b, input int a, input string req);
    exp_cyc[idx]  = cyc;
    exp_cmd[idx]  = int'(c);
    exp_ba[idx]   = b;
    exp_addr[idx] = a;
    exp_req[idx]  = req;
  endtask

  // R12: cycle rules, offsets counted from the cycle in which cke rises
  task automatic build_schedule();
    int c;
    int g_rp, g_rfc, g_mrd, g_lock, g_cke;
    g_rp   = min2(ceil_cyc(RP_NS));
    g_rfc  = min2(ceil_cyc(RFC_NS));
    g_mrd  = min2(MRD);
    g_lock = min2(LOCK);
    g_cke  = min2(CKE_NOP);
    c = g_cke;
    add_exp(0, c, C_PRE, 0, 1 << 10, "R3");
    c += g_rp;
    add_exp(1, c, C_MRS, 1, EMRS, "R4");
    c += g_mrd;
    add_exp(2, c, C_MRS, 0, MODE | (1 << 8), "R5");
    c += g_lock;
    add_exp(3, c, C_PRE, 0, 1 << 10, "R6");
    c += g_rp;
    for (int i = 0; i < NREF; i++) begin
      add_exp(4 + i, c, C_REF, 0, 0, "R7");
      c += g_rfc;
    end
    add_exp(4 + NREF, c, C_MRS, 0, MODE & ~(1 << 8), "R8");
    c += g_mrd;
    exp_done = c;
  endtask

  task automatic check_reset_state(input string what);
    chk(!cke && !done && cur_cmd() == C_NOP && ba == '0 && addr == '0, "R11", what,
        {cke, done, cur_cmd()}, {2'b00, C_NOP});
  endtask

  task automatic run_seq(input int idle_cyc, input bit abort, input int abort_at);
    int bad, low_cnt, idx, off, bad_cke, early;
    bit seen_done;
    rst_n = 1'b0;
    pwr   = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state("state during reset");
    rst_n = 1'b1;

    bad = 0;
    repeat (idle_cyc) begin
      @(negedge clk);
      if (cke || cur_cmd() != C_NOP) bad++;
    end
    chk(bad == 0, "R1", "activity while power-good low", bad, 0);

    pwr = 1'b1;
    low_cnt = 0;
    bad = 0;
    @(negedge clk);
    while (!cke && low_cnt < STABLE_CYC + 10) begin
      if (cur_cmd() != C_NOP) bad++;
      low_cnt++;
      @(negedge clk);
    end
    chk(low_cnt == STABLE_CYC, "R1", "cycles with cke low after power-good", low_cnt, STABLE_CYC);
    chk(bad == 0, "R10", "non-NOP while cke low", bad, 0);
    chk(cur_cmd() == C_NOP, "R2", "command in cke rise cycle", cur_cmd(), C_NOP);

    idx = 0; off = 0; bad_cke = 0; early = 0; seen_done = 1'b0; bad = 0;
    while (!seen_done && off < exp_done + 5) begin
      @(negedge clk);
      off++;
      if (abort && off == abort_at) begin
        rst_n = 1'b0;
        #1;
        check_reset_state("outputs after mid-sequence reset");
        return;
      end
      if (!cke) bad_cke++;
      if (cur_cmd() != C_NOP) begin
        if (idx < N_EXP) begin
          chk(off == exp_cyc[idx], exp_req[idx], "command cycle", off, exp_cyc[idx]);
          chk(int'(cur_cmd()) == exp_cmd[idx], exp_req[idx], "command code", cur_cmd(), exp_cmd[idx]);
          chk(int'(ba) == exp_ba[idx], exp_req[idx], "bank address", ba, exp_ba[idx]);
          chk(int'(addr) == exp_addr[idx], exp_req[idx], "address", addr, exp_addr[idx]);
        end
        idx++;
      end else if (ba != '0 || addr != '0) begin
        bad++;
      end
      if (done) begin
        chk(off == exp_done, "R9", "done cycle", off, exp_done);
        seen_done = 1'b1;
      end
    end
    chk(seen_done, "R9", "done raised", seen_done, 1);
    chk(idx == N_EXP, "R7", "commands issued", idx, N_EXP);
    chk(bad_cke == 0, "R2", "cke drops after rise", bad_cke, 0);
    chk(bad == 0, "R10", "NOP with nonzero bank/address", bad, 0);

    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (!done || !cke || cur_cmd() != C_NOP) bad++;
    end
    chk(bad == 0, "R9", "post-done hold violations", bad, 0);
    early = early;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    build_schedule();
    chk(exp_done == 218, "R12", "schedule length at defaults", exp_done, 218);
    // directed: long power-good wait, then complete
    run_seq(500, 1'b0, 0);
    // directed: reset right after cke rises
    run_seq(3, 1'b1, 1);
    // random idle lengths and abort points
    run_seq($urandom_range(20, 2), 1'b1, $urandom_range(exp_done - 1, 2));
    run_seq($urandom_range(20, 2), 1'b0, 0);
    run_seq($urandom_range(20, 2), 1'b0, 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule